// File: doc/BRIEF.md
# Interleaved Cache Line Fill Controller

This block services a cache miss by fetching a whole line from a memory built as several word-wide banks. Each bank holds one word position of every line. On an accepted miss request the controller spends one cycle sending the line address to all banks at once, and every bank starts its access in that same cycle. The banks therefore overlap their fixed access latency. When the latency has elapsed, the controller captures every bank's word into holding registers. It then streams the words to the cache over a single word-wide path, one word per cycle.

The stream starts with the word the processor missed on and wraps around the end of the line back to word 0. That first word is also presented on a forward strobe, so the processor can restart without waiting for the rest of the line. With the default four banks and a 15-cycle access, a fill takes 1 + 15 + 4 = 20 cycles from acceptance to completion. New requests are refused while a fill is in progress.

Top module: `linefill_ctrl`

## Requirements
- R1: After synchronous reset, busy, bank_start, fill_valid, fwd_valid and done are all 0.
- R2: A request is accepted at a rising edge where req_valid is 1 and busy is 0. In the cycle after that edge, every bit of bank_start is 1 for exactly one cycle. bank_line carries req_addr with its two low bits removed (req_addr[15:2] at default widths). bank_start is 0 in every other cycle.
- R3: busy is 1 from the cycle after acceptance through the cycle in which done is 1. A request presented while busy is 1 is ignored: it starts no bank access and does not change the line or the data being delivered.
- R4: fill_valid is 1 in exactly four consecutive cycles, the 17th to the 20th cycle after the accepting edge. The 17th cycle is one address cycle, plus 15 access cycles, plus one.
- R5: The word index bits are req_addr[1:0], the critical index c. fill_idx runs c, c+1, c+2, c+3 modulo 4 over the four fill cycles.
- R6: Bank b holds the word whose low address bits equal b. The word presented with fill_idx = b is the value bank b returned with bank_valid[b].
- R7: fwd_valid is 1 only in the first fill cycle. In that cycle fwd_data equals the word of the critical index.
- R8: done is 1 only in the fourth fill cycle, the 20th cycle after the accepting edge.
- R9: busy is 0 in the cycle right after done, so a back-to-back request is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request |
| req_addr | input | ADDR_W | Word address of the missed word |
| busy | output | 1 | Fill in progress; requests refused |
| bank_start | output | WORDS | Start pulse, one bit per bank |
| bank_line | output | ADDR_W-log2(WORDS) | Line address shared by all banks |
| bank_valid | input | WORDS | Bank data ready, one bit per bank |
| bank_rdata | input | WORDS*DATA_W | Bank read data, bank b at bits [b*DATA_W +: DATA_W] |
| fill_valid | output | 1 | A line word is on fill_data |
| fill_idx | output | log2(WORDS) | Position of that word in the line |
| fill_data | output | DATA_W | Line word written into the cache |
| fwd_valid | output | 1 | Critical word forwarded to the processor |
| fwd_data | output | DATA_W | Forwarded critical word |
| done | output | 1 | Last word of the line is transferred |

## Verification
Fills are run with the critical index at each of the four positions. Each run checks the full wrap sequence, so a wrong start offset, a missing modulo or a swapped bank is caught.

Bank data encodes both the bank number and the line. Each delivered word therefore shows whether it came from the right bank and the right line.

One fill has a second request with a different address held on the inputs for almost the whole fill, which separates a correct refusal from a restart or a relatched line. Fills are also chained back to back, which exposes an off-by-one in the release of busy or in the 20-cycle timing.

// File: rtl/linefill_pkg.sv
package linefill_pkg;

    typedef enum logic [1:0] {
        LF_IDLE = 2'd0,
        LF_ADDR = 2'd1,
        LF_WAIT = 2'd2,
        LF_XFER = 2'd3
    } lf_state_e;

    // Flags of one transfer cycle on the fill path
    typedef struct packed {
        logic valid;
        logic first;
        logic last;
    } lf_beat_t;

    // Next word position in a line, wrapping at the line end
    function automatic int unsigned lf_wrap_step(int unsigned idx, int unsigned words);
        return (idx + 1) % words;
    endfunction

endpackage

// File: rtl/lf_sequencer.sv
module lf_sequencer
    import linefill_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int WORDS   = 4,
    parameter int ACC_LAT = 15
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             req_valid,
    input  logic [ADDR_W-1:0]                req_addr,
    output logic                             busy,
    output logic                             start_pulse,
    output logic [ADDR_W-$clog2(WORDS)-1:0]  line_addr,
    output lf_beat_t                         beat,
    output logic [$clog2(WORDS)-1:0]         beat_idx
);
    localparam int IDX_W  = $clog2(WORDS);
    localparam int LINE_W = ADDR_W - IDX_W;
    localparam int CNT_W  = $clog2(ACC_LAT + 1);

    lf_state_e            state;
    logic [CNT_W-1:0]     wait_cnt;
    logic [IDX_W-1:0]     beat_cnt;
    logic [LINE_W-1:0]    line_q;
    logic [IDX_W-1:0]     crit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LF_IDLE;
            wait_cnt <= '0;
            beat_cnt <= '0;
            line_q   <= '0;
            crit_q   <= '0;
        end else begin
            case (state)
                LF_IDLE: begin
                    if (req_valid) begin
                        line_q <= req_addr[ADDR_W-1:IDX_W];
                        crit_q <= req_addr[IDX_W-1:0];
                        state  <= LF_ADDR;
                    end
                end
                LF_ADDR: begin
                    wait_cnt <= CNT_W'(ACC_LAT - 1);
                    state    <= LF_WAIT;
                end
                LF_WAIT: begin
                    if (wait_cnt == '0) begin
                        beat_cnt <= '0;
                        state    <= LF_XFER;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                LF_XFER: begin
                    if (beat_cnt == IDX_W'(WORDS - 1)) begin
                        state <= LF_IDLE;
                    end else begin
                        beat_cnt <= beat_cnt + 1'b1;
                    end
                end
                default: state <= LF_IDLE;
            endcase
        end
    end

    assign busy        = (state != LF_IDLE);
    assign start_pulse = (state == LF_ADDR);
    assign line_addr   = line_q;

    always_comb begin
        beat.valid = (state == LF_XFER);
        beat.first = beat.valid && (beat_cnt == '0);
        beat.last  = beat.valid && (beat_cnt == IDX_W'(WORDS - 1));
        beat_idx   = crit_q + beat_cnt;
    end

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !beat.last) |=> busy);

    // R2
    start_once_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> (!start_pulse && busy));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        beat.last |=> !busy);

endmodule

// File: rtl/lf_bank_capture.sv
module lf_bank_capture #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      xfer_first,
    input  logic [WORDS-1:0]          bank_valid,
    input  logic [WORDS*DATA_W-1:0]   bank_rdata,
    output logic [WORDS*DATA_W-1:0]   hold_flat
);
    logic [WORDS-1:0] got;

    for (genvar g = 0; g < WORDS; g++) begin : g_bank
        logic [DATA_W-1:0] hold_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
                got[g] <= 1'b0;
            end else if (clear) begin
                got[g] <= 1'b0;
            end else if (bank_valid[g]) begin
                hold_q <= bank_rdata[g*DATA_W +: DATA_W];
                got[g] <= 1'b1;
            end
        end

        assign hold_flat[g*DATA_W +: DATA_W] = hold_q;
    end

    // R6
    banks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_first |-> (&got));

endmodule

// File: rtl/lf_beat_drive.sv
module lf_beat_drive
    import linefill_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  lf_beat_t                    beat,
    input  logic [$clog2(WORDS)-1:0]    beat_idx,
    input  logic [WORDS*DATA_W-1:0]     hold_flat,
    output logic                        fill_valid,
    output logic [$clog2(WORDS)-1:0]    fill_idx,
    output logic [DATA_W-1:0]           fill_data,
    output logic                        fwd_valid,
    output logic [DATA_W-1:0]           fwd_data,
    output logic                        done
);
    localparam int IDX_W = $clog2(WORDS);

    logic [DATA_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = hold_flat[g*DATA_W +: DATA_W];
    end

    always_comb begin
        fill_valid = beat.valid;
        fill_idx   = beat.valid ? beat_idx : '0;
        fill_data  = beat.valid ? words[beat_idx] : '0;
        fwd_valid  = beat.first;
        fwd_data   = beat.first ? words[beat_idx] : '0;
        done       = beat.last;
    end

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && $past(fill_valid)) |->
            (fill_idx == IDX_W'(lf_wrap_step(int'($past(fill_idx)), WORDS))));

    // R7
    fwd_once_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |=> (fill_valid && !fwd_valid));

    // R8
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (fill_valid && !fwd_valid));

endmodule

// File: rtl/linefill_ctrl.sv
module linefill_ctrl
    import linefill_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int WORDS   = 4,
    parameter int ACC_LAT = 15
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_addr,
    output logic                              busy,
    output logic [WORDS-1:0]                  bank_start,
    output logic [ADDR_W-$clog2(WORDS)-1:0]   bank_line,
    input  logic [WORDS-1:0]                  bank_valid,
    input  logic [WORDS*DATA_W-1:0]           bank_rdata,
    output logic                              fill_valid,
    output logic [$clog2(WORDS)-1:0]          fill_idx,
    output logic [DATA_W-1:0]                 fill_data,
    output logic                              fwd_valid,
    output logic [DATA_W-1:0]                 fwd_data,
    output logic                              done
);
    localparam int IDX_W  = $clog2(WORDS);
    localparam int LINE_W = ADDR_W - IDX_W;

    logic                start_pulse;
    logic [LINE_W-1:0]   line_addr;
    lf_beat_t            beat;
    logic [IDX_W-1:0]    beat_idx;
    logic [WORDS*DATA_W-1:0] hold_flat;

    lf_sequencer #(
        .ADDR_W  (ADDR_W),
        .WORDS   (WORDS),
        .ACC_LAT (ACC_LAT)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .busy        (busy),
        .start_pulse (start_pulse),
        .line_addr   (line_addr),
        .beat        (beat),
        .beat_idx    (beat_idx)
    );

    lf_bank_capture #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .clear      (start_pulse),
        .xfer_first (beat.first),
        .bank_valid (bank_valid),
        .bank_rdata (bank_rdata),
        .hold_flat  (hold_flat)
    );

    lf_beat_drive #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_drv (
        .clk        (clk),
        .rst        (rst),
        .beat       (beat),
        .beat_idx   (beat_idx),
        .hold_flat  (hold_flat),
        .fill_valid (fill_valid),
        .fill_idx   (fill_idx),
        .fill_data  (fill_data),
        .fwd_valid  (fwd_valid),
        .fwd_data   (fwd_data),
        .done       (done)
    );

    assign bank_start = {WORDS{start_pulse}};
    assign bank_line  = line_addr;

endmodule

// File: tb/linefill_ctrl_bench.sv
`timescale 1ns/1ps
module linefill_ctrl_bench;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int LAT    = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic busy;
    logic [WORDS-1:0] bank_start;
    logic [ADDR_W-3:0] bank_line;
    logic [WORDS-1:0] bank_valid;
    logic [WORDS*DATA_W-1:0] bank_rdata;
    logic fill_valid;
    logic [1:0] fill_idx;
    logic [DATA_W-1:0] fill_data;
    logic fwd_valid;
    logic [DATA_W-1:0] fwd_data;
    logic done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    linefill_ctrl u_linefill_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .bank_start(bank_start), .bank_line(bank_line),
        .bank_valid(bank_valid), .bank_rdata(bank_rdata),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_data(fill_data),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .done(done)
    );

    function automatic logic [DATA_W-1:0] exp_word(int b, logic [ADDR_W-3:0] line);
        return {4'(b), 12'h5A3, 2'b00, line};
    endfunction

    // Bank models: fixed latency, data valid for one cycle
    for (genvar b = 0; b < WORDS; b++) begin : g_bank
        int cnt;
        logic [ADDR_W-3:0] line_l;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt <= 0;
                bank_valid[b] <= 1'b0;
                line_l <= '0;
            end else if (bank_start[b]) begin
                cnt <= LAT - 1;
                line_l <= bank_line;
                bank_valid[b] <= 1'b0;
            end else begin
                bank_valid[b] <= (cnt == 1);
                if (cnt != 0) cnt <= cnt - 1;
            end
        end
        assign bank_rdata[b*DATA_W +: DATA_W] = exp_word(b, line_l);
    end

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", 64'(busy), 0);
        chk(bank_start == '0, "R1 bank_start", 64'(bank_start), 0);
        chk(fill_valid == 1'b0, "R1 fill_valid", 64'(fill_valid), 0);
        chk(fwd_valid == 1'b0, "R1 fwd_valid", 64'(fwd_valid), 0);
        chk(done == 1'b0, "R1 done", 64'(done), 0);
    endtask

    // Entered and left at a negedge; runs one fill and checks every cycle
    task automatic t_fill(logic [ADDR_W-1:0] addr, bit spam);
        logic [1:0] crit = addr[1:0];
        logic [ADDR_W-3:0] line = addr[ADDR_W-1:2];
        chk(busy == 1'b0, "R9 busy low before request", 64'(busy), 0);
        req_valid = 1'b1;
        req_addr  = addr;
        @(posedge clk);
        for (int j = 1; j <= 20; j++) begin
            @(negedge clk);
            if (j == 1) begin
                if (spam) req_addr = addr ^ 16'h0155;
                else req_valid = 1'b0;
            end
            if (spam && j == 19) req_valid = 1'b0;
            chk(bank_start == ((j == 1) ? 4'hF : 4'h0), "R2 bank_start",
                64'(bank_start), (j == 1) ? 64'hF : 0);
            if (j == 1) chk(bank_line == line, "R2 bank_line", 64'(bank_line), 64'(line));
            chk(busy == 1'b1, "R3 busy", 64'(busy), 1);
            chk(fill_valid == (j >= 17), "R4 fill_valid", 64'(fill_valid), 64'(j >= 17));
            if (j >= 17) begin
                logic [1:0] ei = crit + 2'(j - 17);
                chk(fill_idx == ei, "R5 fill_idx", 64'(fill_idx), 64'(ei));
                chk(fill_data == exp_word(int'(ei), line),
                    spam ? "R3 R6 fill_data" : "R6 fill_data",
                    64'(fill_data), 64'(exp_word(int'(ei), line)));
            end
            chk(fwd_valid == (j == 17), "R7 fwd_valid", 64'(fwd_valid), 64'(j == 17));
            if (j == 17)
                chk(fwd_data == exp_word(int'(crit), line), "R7 fwd_data",
                    64'(fwd_data), 64'(exp_word(int'(crit), line)));
            chk(done == (j == 20), "R8 done", 64'(done), 64'(j == 20));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_fill(16'h1230, 1'b0);
        @(negedge clk);
        t_fill(16'hBEE1, 1'b0);
        @(negedge clk);
        t_fill(16'h0A42, 1'b1);
        @(negedge clk);
        t_fill(16'h7FFF, 1'b0);
        @(negedge clk);
        chk(busy == 1'b0, "R9 idle after fills", 64'(busy), 0);
        chk(bank_start == '0, "R3 no restart from refused request", 64'(bank_start), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule